// File: doc/BRIEF.md
# Boundary-Tag Heap Allocator Engine

This engine manages a heap of 32-bit words held in its own on-chip RAM. Every block in the heap is framed by two tag words: one just below its first data word and one just after its last. Both tags hold the same signed size, counted in data words. A positive value marks the block as in use and a negative value marks it as free. After reset the engine writes the tags for one free block that covers the whole heap. It then accepts one request at a time.

An allocate request carries a size in bytes. The engine rounds it up to whole words. It walks the blocks from address zero and takes the first free block that can hold the request. If enough is left over, it splits the block. It returns a word pointer to the first data word, or raises an error if nothing fits. A free request carries such a pointer. The engine checks that the tags are sane, marks the block free, and merges it with a free block on either side or both. The merged block takes in the tag words that lay between the parts.

The engine touches its RAM at most once per cycle. It holds busy high from the cycle after it accepts a request until its one-cycle response appears.

Top module: `heap_engine`

## Requirements
- R1: An allocate request (op bit 0) of B bytes asks for ceil(B/4) data words. A request of zero bytes is answered with the error flag.
- R2: Reset leaves the heap as one free block of HEAP_WORDS-2 data words. A request for exactly that many words succeeds with pointer 1. One word more fails.
- R3: Allocation takes the free block at the lowest address whose size is at least the request.
- R4: If the chosen block has size S, the request is W words, and S-W-2 >= MIN_REM, the block is split. The first W words are handed out. A free block of S-W-2 words follows directly after the new trailer.
- R5: If S-W-2 < MIN_REM, the whole block of S words is handed out and nothing remains behind it.
- R6: When no free block is large enough, the response carries the error flag.
- R7: A successful allocation returns the address of the header word plus one. That value lies between 1 and HEAP_WORDS-2.
- R8: A free request (op bit 1) with a valid pointer succeeds. The released block merges with the free block directly below it, the free block directly above it, both, or neither. The merged size covers the absorbed tag words.
- R9: A free request fails with the error flag, and leaves the heap unchanged, in any of these cases: the pointer is 0 or above HEAP_WORDS-2; the header is not positive; the header does not fit in the heap; the trailer differs from the header.
- R10: busy_o is high during the reset initialisation and from the cycle after a request is accepted until the response. rsp_valid_o lasts one cycle with busy_o low. A request presented while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is low |
| req_op_i | input | 1 | 0 allocate, 1 free |
| req_bytes_i | input | BYTE_W | Allocation size in bytes |
| req_ptr_i | input | AW | Pointer to release |
| busy_o | output | 1 | Engine working or initialising |
| rsp_valid_o | output | 1 | Response strobe, one cycle |
| rsp_err_o | output | 1 | Request failed |
| rsp_ptr_o | output | AW | Allocated pointer, or the freed pointer echoed |

## Verification
The bench builds the engine with a 500-word heap and MIN_REM set to 2. The heap size makes pointers such as 1, 13 and 497 predictable. The raised minimum makes a remainder of exactly one word fall on the no-split side and a remainder of two words fall on the split side.

Directed sequences create each of the four merge shapes and then prove the merged size with an allocation that fits exactly. A randomised mix of allocations up to 400 bytes and frees of live pointers fills the heap often enough to exercise exhaustion and fragmentation against a tag-level model.

// File: rtl/heap_pkg.sv
package heap_pkg;
  typedef logic signed [31:0] tag_t;

  typedef enum logic {
    OP_ALLOC = 1'b0,
    OP_FREE  = 1'b1
  } heap_op_e;

  typedef enum logic [4:0] {
    S_INIT_H, S_INIT_T, S_IDLE, S_SCAN,
    S_AL_H, S_AL_T, S_AL_RH, S_AL_RT,
    S_FR_H, S_FR_T, S_FR_LO, S_FR_HI,
    S_FR_WH, S_FR_WT, S_FR_MH, S_FR_MT,
    S_FAIL
  } heap_st_e;
endpackage

// File: rtl/heap_ram.sv
module heap_ram #(
  parameter int DEPTH = 500,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  // R2: no tag is ever placed outside the heap
  p_wr_inside_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(addr_i) < DEPTH));
endmodule

// File: rtl/heap_sizer.sv
module heap_sizer #(
  parameter int BYTE_W = 16,
  parameter int WW     = BYTE_W - 1
) (
  input  logic [BYTE_W-1:0] bytes_i,
  output logic [WW-1:0]     words_o,
  output logic              zero_o
);
  // round up to whole 32-bit words
  assign words_o = WW'(bytes_i[BYTE_W-1:2]) + WW'(|bytes_i[1:0]);
  assign zero_o  = (bytes_i == '0);
endmodule

// File: rtl/heap_fsm.sv
module heap_fsm
  import heap_pkg::*;
#(
  parameter int HEAP_WORDS = 500,
  parameter int MIN_REM    = 1,
  parameter int AW         = $clog2(HEAP_WORDS),
  parameter int WW         = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_op_i,
  input  logic [WW-1:0] need_i,
  input  logic          zero_i,
  input  logic [AW-1:0] req_ptr_i,
  output logic          busy_o,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [AW-1:0] rsp_ptr_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [31:0]   ram_wdata_o,
  input  logic [31:0]   ram_rdata_i
);
  localparam tag_t NW  = tag_t'(HEAP_WORDS);
  localparam tag_t MRM = tag_t'(MIN_REM);

  heap_st_e st;
  heap_op_e op;
  tag_t cur, need, bsz, rem, lo, hi;
  logic split;

  tag_t rd, mag, rem_v, addr_w, merged;
  logic fit, walk_end, merge_any;

  assign rd        = tag_t'(ram_rdata_i);
  assign mag       = rd[31] ? -rd : rd;
  assign rem_v     = mag - need - 2;
  assign fit       = rd < 0 && mag > 0 && mag >= need;
  assign walk_end  = rd == 0 || mag < 0 || mag >= NW - cur - 2;
  assign merged    = hi - lo - 1;
  assign merge_any = (lo != cur) || (hi != cur + bsz + 1);
  assign busy_o    = (st != S_IDLE);

  always_comb begin
    ram_we_o    = 1'b0;
    addr_w      = cur;
    ram_wdata_o = '0;
    unique case (st)
      S_INIT_H: begin ram_we_o = 1'b1; addr_w = 0;      ram_wdata_o = -(NW - 2); end
      S_INIT_T: begin ram_we_o = 1'b1; addr_w = NW - 1; ram_wdata_o = -(NW - 2); end
      S_AL_H:   begin ram_we_o = 1'b1; ram_wdata_o = need; end
      S_AL_T:   begin ram_we_o = 1'b1; addr_w = cur + need + 1; ram_wdata_o = need; end
      S_AL_RH:  begin ram_we_o = 1'b1; addr_w = cur + need + 2; ram_wdata_o = -rem; end
      S_AL_RT:  begin ram_we_o = 1'b1; addr_w = cur + need + rem + 3; ram_wdata_o = -rem; end
      S_FR_T:   addr_w = cur + bsz + 1;
      S_FR_LO:  addr_w = cur - 1;
      S_FR_HI:  addr_w = cur + bsz + 2;
      S_FR_WH:  begin ram_we_o = 1'b1; ram_wdata_o = -bsz; end
      S_FR_WT:  begin ram_we_o = 1'b1; addr_w = cur + bsz + 1; ram_wdata_o = -bsz; end
      S_FR_MH:  begin ram_we_o = 1'b1; addr_w = lo; ram_wdata_o = -merged; end
      S_FR_MT:  begin ram_we_o = 1'b1; addr_w = hi; ram_wdata_o = -merged; end
      default:  ;
    endcase
  end
  assign ram_addr_o = AW'(addr_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_INIT_H; op <= OP_ALLOC; split <= 1'b0;
      cur <= '0; need <= '0; bsz <= '0; rem <= '0; lo <= '0; hi <= '0;
      rsp_valid_o <= 1'b0; rsp_err_o <= 1'b0; rsp_ptr_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st)
        S_INIT_H: st <= S_INIT_T;
        S_INIT_T: st <= S_IDLE;
        S_IDLE: if (req_valid_i) begin
          op <= heap_op_e'(req_op_i);
          if (req_op_i == OP_ALLOC) begin
            need <= tag_t'(need_i);
            cur  <= '0;
            st   <= zero_i ? S_FAIL : S_SCAN;
          end else begin
            cur <= tag_t'(req_ptr_i) - 1;
            st  <= (req_ptr_i == '0 || tag_t'(req_ptr_i) > NW - 2) ? S_FAIL : S_FR_H;
          end
        end
        S_SCAN: begin
          if (fit) begin
            if (rem_v >= MRM) begin rem <= rem_v; split <= 1'b1; end
            else begin need <= mag; split <= 1'b0; end
            st <= S_AL_H;
          end else if (walk_end) st <= S_FAIL;
          else cur <= cur + mag + 2;
        end
        S_AL_H:  st <= S_AL_T;
        S_AL_T:  if (split) st <= S_AL_RH;
                 else begin
                   st <= S_IDLE; rsp_valid_o <= 1'b1; rsp_err_o <= 1'b0; rsp_ptr_o <= AW'(cur + 1);
                 end
        S_AL_RH: st <= S_AL_RT;
        S_AL_RT: begin
          st <= S_IDLE; rsp_valid_o <= 1'b1; rsp_err_o <= 1'b0; rsp_ptr_o <= AW'(cur + 1);
        end
        S_FR_H: begin
          if (rd <= 0 || rd > NW - 2 - cur) st <= S_FAIL;
          else begin bsz <= rd; st <= S_FR_T; end
        end
        S_FR_T: begin
          if (rd != bsz) st <= S_FAIL;
          else begin
            lo <= cur;
            hi <= cur + bsz + 1;
            if (cur > 0) st <= S_FR_LO;
            else st <= (cur + bsz + 2 < NW) ? S_FR_HI : S_FR_WH;
          end
        end
        S_FR_LO: begin
          if (rd < 0) lo <= cur + rd - 2;
          st <= (cur + bsz + 2 < NW) ? S_FR_HI : S_FR_WH;
        end
        S_FR_HI: begin
          if (rd < 0) hi <= cur + bsz + 3 - rd;
          st <= S_FR_WH;
        end
        S_FR_WH: st <= S_FR_WT;
        S_FR_WT: if (merge_any) st <= S_FR_MH;
                 else begin
                   st <= S_IDLE; rsp_valid_o <= 1'b1; rsp_err_o <= 1'b0; rsp_ptr_o <= AW'(cur + 1);
                 end
        S_FR_MH: st <= S_FR_MT;
        S_FR_MT: begin
          st <= S_IDLE; rsp_valid_o <= 1'b1; rsp_err_o <= 1'b0; rsp_ptr_o <= AW'(cur + 1);
        end
        S_FAIL: begin
          st <= S_IDLE; rsp_valid_o <= 1'b1; rsp_err_o <= 1'b1; rsp_ptr_o <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rsp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !busy_o);
  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  p_accept_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  p_ptr_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && op == OP_ALLOC) |->
      (rsp_ptr_o != '0 && tag_t'(rsp_ptr_o) <= NW - 2));
  p_bad_hdr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_FR_H && rd <= 0) |=> (st == S_FAIL));
  p_fail_nowrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_FAIL) |-> !ram_we_o);
endmodule

// File: rtl/heap_engine.sv
module heap_engine #(
  parameter int HEAP_WORDS = 500,
  parameter int MIN_REM    = 1,
  parameter int BYTE_W     = 16,
  localparam int AW        = $clog2(HEAP_WORDS),
  localparam int WW        = BYTE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_op_i,
  input  logic [BYTE_W-1:0] req_bytes_i,
  input  logic [AW-1:0]     req_ptr_i,
  output logic              busy_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [AW-1:0]     rsp_ptr_o
);
  logic [WW-1:0] need_w;
  logic          zero_w;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [31:0]   ram_wdata, ram_rdata;

  heap_sizer #(.BYTE_W(BYTE_W), .WW(WW)) u_sizer (
    .bytes_i(req_bytes_i), .words_o(need_w), .zero_o(zero_w)
  );

  heap_fsm #(.HEAP_WORDS(HEAP_WORDS), .MIN_REM(MIN_REM), .AW(AW), .WW(WW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .need_i(need_w), .zero_i(zero_w), .req_ptr_i(req_ptr_i),
    .busy_o(busy_o), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_ptr_o(rsp_ptr_o),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  heap_ram #(.DEPTH(HEAP_WORDS), .AW(AW)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ram_we), .addr_i(ram_addr),
    .wdata_i(ram_wdata), .rdata_o(ram_rdata)
  );
endmodule

// File: tb/sim_heap_engine.sv
module sim_heap_engine;
  localparam int N  = 500;
  localparam int MR = 2;
  localparam int BW = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [BW-1:0] req_bytes = '0;
  logic [AW-1:0] req_ptr = '0;
  logic busy, rsp_valid, rsp_err;
  logic [AW-1:0] rsp_ptr;

  int errs = 0, checks = 0;
  int m [N];

  always #5 clk = ~clk;

  heap_engine #(.HEAP_WORDS(N), .MIN_REM(MR), .BYTE_W(BW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_bytes_i(req_bytes), .req_ptr_i(req_ptr), .busy_o(busy),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_ptr_o(rsp_ptr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tag-level model of the heap as the requirements define it
  function automatic void m_init();
    for (int i = 0; i < N; i++) m[i] = 0;
    m[0] = -(N - 2); m[N-1] = -(N - 2);
  endfunction

  function automatic int m_alloc(int bytes);
    int need, cur, s, sz, rem;
    if (bytes == 0) return -1;
    need = (bytes + 3) / 4;
    cur = 0;
    while (cur < N) begin
      s = m[cur];
      sz = (s < 0) ? -s : s;
      if (s < 0 && sz >= need) begin
        rem = sz - need - 2;
        if (rem >= MR) begin
          m[cur] = need; m[cur+need+1] = need;
          m[cur+need+2] = -rem; m[cur+sz+1] = -rem;
        end else begin
          m[cur] = sz; m[cur+sz+1] = sz;
        end
        return cur + 1;
      end
      cur = cur + sz + 2;
    end
    return -1;
  endfunction

  function automatic int m_free(int p);
    int h, s, lo, hi;
    if (p < 1 || p > N - 2) return 1;
    h = p - 1; s = m[h];
    if (s <= 0 || h + s + 1 > N - 1) return 1;
    if (m[h+s+1] != s) return 1;
    m[h] = -s; m[h+s+1] = -s;
    lo = h; hi = h + s + 1;
    if (h > 0 && m[h-1] < 0) lo = h - 1 + m[h-1] - 1;
    if (hi + 1 < N && m[hi+1] < 0) hi = hi + 1 - m[hi+1] + 1;
    m[lo] = -(hi - lo - 1); m[hi] = -(hi - lo - 1);
    return 0;
  endfunction

  task automatic do_req(input bit op, input int bytes, input int ptr, output bit err, output int rp);
    while (busy) @(negedge clk);
    req_op = op; req_bytes = BW'(bytes); req_ptr = AW'(ptr); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    err = rsp_err; rp = int'(rsp_ptr);
  endtask

  // exp_hard: -2 compare with model only, -1 expect error, else expected pointer
  task automatic alloc_chk(input int bytes, input int exp_hard, input string req);
    bit err; int rp, e, got;
    e = m_alloc(bytes);
    do_req(1'b0, bytes, 0, err, rp);
    got = err ? -1 : rp;
    if (exp_hard != -2) chk(got == exp_hard, req, got, exp_hard);
    else chk(got == e, req, got, e);
  endtask

  task automatic free_chk(input int ptr, input bit exp_err, input string req);
    bit err; int rp, e;
    e = m_free(ptr);
    do_req(1'b1, 0, ptr, err, rp);
    chk(err == exp_err && e == int'(exp_err), req, int'(err), int'(exp_err));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_init();
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && rsp_valid == 1'b0, "R10 busy held in reset", int'(busy), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy during init", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit err; int rp;
    int live [128];
    int nl;
    void'($urandom(32'd2024));

    // phase A: split, whole-block hand-out, exhaustion, busy ignore
    do_reset();
    alloc_chk(40, 1, "R7 first pointer");
    // R10: request while busy must be ignored (free of ptr 1 pulsed mid-walk)
    while (busy) @(negedge clk);
    req_op = 1'b0; req_bytes = BW'(1932); req_valid = 1'b1;
    @(negedge clk);
    void'(m_alloc(1932));
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    req_op = 1'b1; req_ptr = AW'(1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(!rsp_err && int'(rsp_ptr) == 13, "R5 remainder of one word stays inside", int'(rsp_ptr), 13);
    alloc_chk(4, -1, "R6 heap full / R10 ignored free");

    // phase B: rounding, full heap, exact split
    do_reset();
    alloc_chk(0, -1, "R1 zero bytes");
    alloc_chk(4 * (N - 1), -1, "R2 one word too many");
    alloc_chk(4 * (N - 2), 1, "R2 whole heap");
    free_chk(1, 1'b0, "R8 free whole heap");
    alloc_chk(37, 1, "R1 37 bytes is 10 words");
    alloc_chk(1928, 13, "R4 split with two-word remainder");
    alloc_chk(4, 497, "R4 remainder placed after trailer");
    alloc_chk(4, -1, "R6 nothing left");

    // phase C: four merge shapes and first fit
    do_reset();
    alloc_chk(40, 1, "R7 block A");
    alloc_chk(40, 13, "R7 block B");
    alloc_chk(40, 25, "R7 block C");
    free_chk(13, 1'b0, "R8 free with no free neighbour");
    alloc_chk(40, 13, "R3 first fit reuses hole");
    free_chk(13, 1'b0, "R8 free B again");
    free_chk(1, 1'b0, "R8 free A, higher neighbour free");
    alloc_chk(88, 1, "R8 merged A+B is 22 words");
    free_chk(1, 1'b0, "R8 release merged block");
    free_chk(25, 1'b0, "R8 free C, both neighbours free");
    alloc_chk(4 * (N - 2), 1, "R8 both-side merge restores heap");
    free_chk(1, 1'b0, "R8 release heap");
    alloc_chk(40, 1, "R3 A again");
    alloc_chk(40, 13, "R3 B again");
    alloc_chk(40, 25, "R3 C again");
    free_chk(1, 1'b0, "R8 free A");
    free_chk(13, 1'b0, "R8 free B, lower neighbour free");
    alloc_chk(88, 1, "R8 lower merge gives 22 words");
    free_chk(1, 1'b0, "R8 release");
    free_chk(25, 1'b0, "R8 free C");
    alloc_chk(40, 1, "R3 A");
    alloc_chk(40, 13, "R3 B");
    free_chk(13, 1'b0, "R8 free B, only higher neighbour free");
    alloc_chk(4 * 486, 13, "R8 higher merge gives 486 words");

    // phase D: bad frees
    free_chk(0, 1'b1, "R9 null pointer");
    free_chk(N - 1, 1'b1, "R9 pointer past heap");
    free_chk(13, 1'b0, "R9 valid free before double free");
    free_chk(13, 1'b1, "R9 double free, header negative");
    alloc_chk(4 * 486, 13, "R9 heap unchanged after bad frees");

    // phase E: random mix against the model
    do_reset();
    nl = 0;
    for (int k = 0; k < 400; k++) begin
      int choose;
      choose = int'($urandom % 4);
      if (nl == 0 || (choose != 0 && nl < 128)) begin
        int bytes, e, got;
        bytes = 1 + int'($urandom % 400);
        e = m_alloc(bytes);
        do_req(1'b0, bytes, 0, err, rp);
        got = err ? -1 : rp;
        chk(got == e, "R3 R4 R5 R6 random alloc", got, e);
        if (e > 0) begin live[nl] = e; nl++; end
      end else begin
        int idx, p, e;
        idx = int'($urandom % nl);
        p = live[idx];
        live[idx] = live[nl-1];
        nl--;
        e = m_free(p);
        do_req(1'b1, 0, p, err, rp);
        chk(int'(err) == e && e == 0, "R8 random free", int'(err), e);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule